// File: doc/BRIEF.md
# Dual-Direction Latched/Registered Bus Transceiver

This block sits between two 18-bit buses, called side A and side B, and carries data across in both directions. Each direction has its own storage and its own set of four controls: an active-low drive enable, a pass-through select, a transfer strobe and an active-low strobe enable. When pass-through is selected, the stored value follows the incoming data. When pass-through is off, the incoming data is captured on a falling edge of the strobe, but only while the strobe enable is low. In every other case the stored value is held.

All controls are asynchronous to the block. They pass through a two-stage synchronizer on the free-running system clock. A strobe falling edge is detected when the previous synchronized sample is 1 and the current one is 0. Each direction runs a small state machine with these states:
- `ST_RESET`: entered while reset is held.
- `ST_FLOW`: pass-through.
- `ST_HOLD`: storage only changes on an enabled strobe fall.

The transitions are:
- `ST_RESET` to `ST_FLOW` or `ST_HOLD` after reset, chosen by the synchronized pass-through select.
- `ST_FLOW` to `ST_HOLD` when the select falls.
- `ST_HOLD` to `ST_FLOW` when the select rises.

The block does not contain the tri-state buffers; they are built at chip level. Each direction gives them a data output and a drive enable. The drive enable gates only the buffers: storage goes on updating while the buffers are off. A control change shows at the outputs within four system-clock cycles.

Top module: `dual_store_xcvr`

## Requirements
- R1: While `rst` is high, both drive enables are 0. After a synchronous reset, both stored values read as zero.
- R2: A drive enable is 1 only when its direction's active-low drive-enable input is low. It is 0 within four cycles of that input going high.
- R3: With the pass-through select high, the data output equals that direction's input data, delayed by one system-clock cycle.
- R4: With pass-through low and strobe enable low, a high-to-low strobe transition captures the input data.
- R5: With pass-through low, a steady strobe or a rising strobe leaves the stored value unchanged, whatever the input data does.
- R6: With pass-through low and strobe enable high, strobe falls are ignored and the stored value is held.
- R7: When pass-through falls, the direction holds the last value that passed through.
- R8: Storage updates while the drive enable is 0, and the new value is seen once driving resumes.
- R9: Pass-through takes priority over the strobe. A strobe fall while pass-through is high has no effect beyond pass-through.
- R10: The two directions are independent. Activity on one never changes the other's data output or drive enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | 18 | Data arriving from side A |
| b_in | input | 18 | Data arriving from side B |
| ab_oe_n | input | 1 | A-to-B drive enable, active low |
| ab_le | input | 1 | A-to-B pass-through select |
| ab_ck | input | 1 | A-to-B transfer strobe (falling edge) |
| ab_cken_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A drive enable, active low |
| ba_le | input | 1 | B-to-A pass-through select |
| ba_ck | input | 1 | B-to-A transfer strobe (falling edge) |
| ba_cken_n | input | 1 | B-to-A strobe enable, active low |
| b_out | output | 18 | Data toward side B buffers |
| b_drv | output | 1 | Side B buffer enable |
| a_out | output | 18 | Data toward side A buffers |
| a_drv | output | 1 | Side A buffer enable |

## Verification
The hardest case to reach is a captured value changing while the buffers are off. This needs pass-through dropped, a strobe rise and fall with the enable low, and the drive enable held high, all at once. The stimulus table walks there one control at a time. Each step is held longer than the synchronizer latency, and data is kept steady across each strobe edge. The bench then turns driving back on and checks that the new value appears. Gated strobe falls and rising edges are applied with the input data changed to a value that must not appear at the output.

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_FLOW  = 2'd1,
        ST_HOLD  = 2'd2
    } path_state_t;

    typedef struct packed {
        logic oe_n;
        logic le;
        logic ck;
        logic cken_n;
    } ctl_t;

    localparam int CTL_W = $bits(ctl_t);
    localparam ctl_t CTL_IDLE = '{oe_n: 1'b1, le: 1'b0, ck: 1'b0, cken_n: 1'b1};

endpackage

// File: rtl/xcvr_ctl_sync.sv
`timescale 1ns/1ps
module xcvr_ctl_sync #(
    parameter int         W       = 4,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= d;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/xcvr_store_path.sv
`timescale 1ns/1ps
module xcvr_store_path
    import xcvr_pkg::*;
#(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  ctl_t         ctl_s,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drv
);
    path_state_t  st, st_nxt;
    logic         ck_prev;
    logic         fall_seen;
    logic         capture;
    logic [W-1:0] store_q;

    always_comb fall_seen = ck_prev & ~ctl_s.ck;

    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_RESET: st_nxt = ctl_s.le ? ST_FLOW : ST_HOLD;
            ST_FLOW:  if (!ctl_s.le) st_nxt = ST_HOLD;
            ST_HOLD:  if (ctl_s.le)  st_nxt = ST_FLOW;
            default:  st_nxt = ST_RESET;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) st <= ST_RESET;
        else     st <= st_nxt;
    end

    // storage: pass-through wins over the strobe
    always_comb capture = (st_nxt == ST_FLOW) ||
                          ((st_nxt == ST_HOLD) && fall_seen && !ctl_s.cken_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            ck_prev <= 1'b0;
            store_q <= '0;
        end else begin
            ck_prev <= ctl_s.ck;
            if (capture) store_q <= din;
        end
    end

    // outputs
    always_comb begin
        dout = store_q;
        drv  = !rst && (st != ST_RESET) && !ctl_s.oe_n;
    end
endmodule

// File: rtl/dual_store_xcvr.sv
`timescale 1ns/1ps
module dual_store_xcvr
    import xcvr_pkg::*;
#(
    parameter int W      = 18,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_ck,
    input  logic         ab_cken_n,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_ck,
    input  logic         ba_cken_n,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    output logic [W-1:0] a_out,
    output logic         a_drv
);
    localparam int NDIR = 2;

    ctl_t         ctl_raw [NDIR];
    ctl_t         ctl_s   [NDIR];
    logic [W-1:0] din     [NDIR];
    logic [W-1:0] dout    [NDIR];
    logic         drv     [NDIR];

    always_comb begin
        ctl_raw[0] = '{oe_n: ab_oe_n, le: ab_le, ck: ab_ck, cken_n: ab_cken_n};
        ctl_raw[1] = '{oe_n: ba_oe_n, le: ba_le, ck: ba_ck, cken_n: ba_cken_n};
        din[0]     = a_in;
        din[1]     = b_in;
    end

    for (genvar g = 0; g < NDIR; g++) begin : g_dir
        logic [CTL_W-1:0] sync_q;

        xcvr_ctl_sync #(
            .W       (CTL_W),
            .STAGES  (STAGES),
            .RST_VAL (CTL_IDLE)
        ) u_sync (
            .clk (clk),
            .rst (rst),
            .d   (ctl_raw[g]),
            .q   (sync_q)
        );

        always_comb ctl_s[g] = ctl_t'(sync_q);

        xcvr_store_path #(.W(W)) u_path (
            .clk   (clk),
            .rst   (rst),
            .ctl_s (ctl_s[g]),
            .din   (din[g]),
            .dout  (dout[g]),
            .drv   (drv[g])
        );
    end

    assign b_out = dout[0];
    assign b_drv = drv[0];
    assign a_out = dout[1];
    assign a_drv = drv[1];
endmodule

// File: rtl/xcvr_checker.sv
`timescale 1ns/1ps
module xcvr_checker #(
    parameter int W = 18
) (
    input logic         clk,
    input logic         rst,
    input logic [W-1:0] a_in,
    input logic [W-1:0] b_in,
    input logic         ab_oe_n,
    input logic         ab_le,
    input logic         ab_cken_n,
    input logic         ba_oe_n,
    input logic         ba_le,
    input logic         ba_cken_n,
    input logic [W-1:0] b_out,
    input logic         b_drv,
    input logic [W-1:0] a_out,
    input logic         a_drv
);
    logic [2:0] since_rst;
    logic       settled;

    always_ff @(posedge clk) begin
        if (rst)                 since_rst <= '0;
        else if (since_rst != 3'd4) since_rst <= since_rst + 3'd1;
    end
    assign settled = (since_rst == 3'd4);

    always_comb begin
        if (rst) p_rst_nodrive_r1: assert (!b_drv && !a_drv);
    end

    p_rst_clear_r1: assert property (@(posedge clk)
        rst |=> (b_out == '0) && (a_out == '0));

    p_ab_off_r2: assert property (@(posedge clk) disable iff (rst)
        (settled && ab_oe_n && $past(ab_oe_n) && $past(ab_oe_n, 2)) |=> !b_drv);

    p_ba_off_r2: assert property (@(posedge clk) disable iff (rst)
        (settled && ba_oe_n && $past(ba_oe_n) && $past(ba_oe_n, 2)) |=> !a_drv);

    p_ab_flow_r3: assert property (@(posedge clk) disable iff (rst)
        (settled && ab_le && $past(ab_le) && $past(ab_le, 2) && $past(ab_le, 3))
        |=> (b_out == $past(a_in)));

    p_ba_flow_r3: assert property (@(posedge clk) disable iff (rst)
        (settled && ba_le && $past(ba_le) && $past(ba_le, 2) && $past(ba_le, 3))
        |=> (a_out == $past(b_in)));

    p_ab_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (settled && !ab_le && ab_cken_n && !$past(ab_le) && $past(ab_cken_n)
         && !$past(ab_le, 2) && $past(ab_cken_n, 2)
         && !$past(ab_le, 3) && $past(ab_cken_n, 3)) |=> $stable(b_out));

    p_ba_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (settled && !ba_le && ba_cken_n && !$past(ba_le) && $past(ba_cken_n)
         && !$past(ba_le, 2) && $past(ba_cken_n, 2)
         && !$past(ba_le, 3) && $past(ba_cken_n, 3)) |=> $stable(a_out));
endmodule

bind dual_store_xcvr xcvr_checker #(.W(W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .a_in      (a_in),
    .b_in      (b_in),
    .ab_oe_n   (ab_oe_n),
    .ab_le     (ab_le),
    .ab_cken_n (ab_cken_n),
    .ba_oe_n   (ba_oe_n),
    .ba_le     (ba_le),
    .ba_cken_n (ba_cken_n),
    .b_out     (b_out),
    .b_drv     (b_drv),
    .a_out     (a_out),
    .a_drv     (a_drv)
);

// File: tb/dual_store_xcvr_tb.sv
`timescale 1ns/1ps
module dual_store_xcvr_tb;
    localparam int W     = 18;
    localparam int NROWS = 16;
    localparam int SETTLE = 6;

    typedef struct packed {
        logic [W-1:0] d;
        logic         le;
        logic         ck;
        logic         cken_n;
        logic         oe_n;
        logic [W-1:0] exp_q;
        logic         exp_drv;
    } vec_t;

    // d, le, ck, cken_n, oe_n, expected out, expected drive
    localparam vec_t TBL [NROWS] = '{
        '{18'h12345, 1'b1, 1'b0, 1'b1, 1'b0, 18'h12345, 1'b1}, // R3
        '{18'h0ABCD, 1'b1, 1'b0, 1'b1, 1'b0, 18'h0ABCD, 1'b1}, // R3
        '{18'h0ABCD, 1'b0, 1'b0, 1'b1, 1'b0, 18'h0ABCD, 1'b1}, // R7
        '{18'h3FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 18'h0ABCD, 1'b1}, // R5
        '{18'h3FFFF, 1'b0, 1'b1, 1'b1, 1'b0, 18'h0ABCD, 1'b1}, // R6
        '{18'h3FFFF, 1'b0, 1'b0, 1'b1, 1'b0, 18'h0ABCD, 1'b1}, // R6
        '{18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 18'h0ABCD, 1'b1}, // R5
        '{18'h3FFFF, 1'b0, 1'b1, 1'b0, 1'b0, 18'h0ABCD, 1'b1}, // R5
        '{18'h3FFFF, 1'b0, 1'b0, 1'b0, 1'b0, 18'h3FFFF, 1'b1}, // R4
        '{18'h15555, 1'b0, 1'b0, 1'b0, 1'b1, 18'h3FFFF, 1'b0}, // R2
        '{18'h15555, 1'b0, 1'b1, 1'b0, 1'b1, 18'h3FFFF, 1'b0}, // R8
        '{18'h15555, 1'b0, 1'b0, 1'b0, 1'b1, 18'h15555, 1'b0}, // R8
        '{18'h15555, 1'b0, 1'b0, 1'b0, 1'b0, 18'h15555, 1'b1}, // R8
        '{18'h2AAAA, 1'b1, 1'b1, 1'b0, 1'b0, 18'h2AAAA, 1'b1}, // R9
        '{18'h00F0F, 1'b1, 1'b0, 1'b0, 1'b0, 18'h00F0F, 1'b1}, // R9
        '{18'h00F0F, 1'b0, 1'b0, 1'b0, 1'b0, 18'h00F0F, 1'b1}  // R7
    };

    string row_req [NROWS] = '{"R3", "R3", "R7", "R5", "R6", "R6", "R5", "R5",
                               "R4", "R2", "R8", "R8", "R8", "R9", "R9", "R7"};

    logic         clk = 1'b0;
    logic         rst;
    logic [W-1:0] a_in, b_in;
    logic         ab_oe_n, ab_le, ab_ck, ab_cken_n;
    logic         ba_oe_n, ba_le, ba_ck, ba_cken_n;
    logic [W-1:0] b_out, a_out;
    logic         b_drv, a_drv;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    dual_store_xcvr #(.W(W)) u_dut (
        .clk (clk), .rst (rst),
        .a_in (a_in), .b_in (b_in),
        .ab_oe_n (ab_oe_n), .ab_le (ab_le), .ab_ck (ab_ck), .ab_cken_n (ab_cken_n),
        .ba_oe_n (ba_oe_n), .ba_le (ba_le), .ba_ck (ba_ck), .ba_cken_n (ba_cken_n),
        .b_out (b_out), .b_drv (b_drv), .a_out (a_out), .a_drv (a_drv)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        a_in = '0; b_in = '0;
        ab_oe_n = 1'b0; ab_le = 1'b0; ab_ck = 1'b0; ab_cken_n = 1'b1;
        ba_oe_n = 1'b1; ba_le = 1'b0; ba_ck = 1'b0; ba_cken_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: no drive during reset even with ab_oe_n low
        check("R1", "b_drv in reset", {17'd0, b_drv}, '0);
        check("R1", "a_drv in reset", {17'd0, a_drv}, '0);
        ab_oe_n = 1'b1;
        rst = 1'b0;
        settle();
        check("R1", "b_out after reset", b_out, '0);
        check("R1", "a_out after reset", a_out, '0);

        // stimulus table, A-to-B only
        for (int i = 0; i < NROWS; i++) begin
            a_in      = TBL[i].d;
            ab_le     = TBL[i].le;
            ab_ck     = TBL[i].ck;
            ab_cken_n = TBL[i].cken_n;
            ab_oe_n   = TBL[i].oe_n;
            settle();
            check(row_req[i], $sformatf("row %0d b_out", i), b_out, TBL[i].exp_q);
            check(row_req[i], $sformatf("row %0d b_drv", i), {17'd0, b_drv},
                  {17'd0, TBL[i].exp_drv});
        end
        // R10: B-to-A untouched by all of the above
        check("R10", "a_out idle", a_out, '0);
        check("R10", "a_drv idle", {17'd0, a_drv}, '0);

        // directed B-to-A
        ba_oe_n = 1'b0; ba_le = 1'b1; b_in = 18'h1E1E1;
        settle();
        check("R3", "a_out pass-through", a_out, 18'h1E1E1);
        check("R2", "a_drv on", {17'd0, a_drv}, 18'd1);
        ba_le = 1'b0;
        settle();
        b_in = 18'h0000F;
        ba_ck = 1'b1; settle();
        ba_ck = 1'b0; settle();
        check("R6", "a_out gated strobe", a_out, 18'h1E1E1);
        b_in = 18'h2D2D2; ba_cken_n = 1'b0;
        settle();
        ba_ck = 1'b1; settle();
        ba_ck = 1'b0; settle();
        check("R4", "a_out strobe capture", a_out, 18'h2D2D2);
        ba_oe_n = 1'b1;
        settle();
        check("R2", "a_drv off", {17'd0, a_drv}, '0);
        check("R10", "b_out unchanged by B-to-A", b_out, 18'h00F0F);
        check("R10", "b_drv unchanged by B-to-A", {17'd0, b_drv}, 18'd1);

        // reset in mid-operation
        ba_oe_n = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        check("R1", "b_drv under reset", {17'd0, b_drv}, '0);
        check("R1", "a_drv under reset", {17'd0, a_drv}, '0);
        ab_le = 1'b0; ab_cken_n = 1'b1; ba_cken_n = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        settle();
        check("R1", "b_out cleared", b_out, '0);
        check("R1", "a_out cleared", a_out, '0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule